// File: doc/BRIEF.md
# Programmable Prescaler with Pin Clock Selector

This block divides the incoming oscillator clock by an even, programmable ratio and produces a square reference clock, here called the prescaled clock. Two slower taps are derived from the prescaled clock, one at 1/64 and one at 1/512 of its rate. A four-way selector picks the raw oscillator, the prescaled clock or one of the two taps. When the clock output is enabled, the selected clock replaces the data bit of one of four general output pins.

Software configures the block through a small 4-bit register bus with a 2-bit address. Address 0 holds the division setting. Address 1 holds the clock-output control: bit 3 is the enable, bit 2 always reads as zero, and bits 1:0 are the selector. Address 2 holds the four pin data bits. Address 3 holds the four per-pin high-impedance bits. Writes take effect at the clock edge on which `busWr` is high. Reads are combinational.

Every pin has an output value and an output-enable. The clock-carrying pin (pin 3) must have its data bit held at one by software while the clock output is in use. A change to the division setting only takes hold at the next terminal count of the divider, so the prescaled clock never shows a shortened half-period.

Top module: `prs_clkout`

## Requirements
- R1: After reset, the following hold: the setting (address 0) reads 15; the control register (address 1) reads 0; the pin data (address 2) reads 4'hF; the high-impedance bits (address 3) read 0; `pinOut` is 4'hF; `pinOe` is 4'hF; `prsClk` is 0.
- R2: For a setting s (0..15), `prsClk` stays high for exactly s+1 clock cycles and low for exactly s+1 clock cycles. Its period is therefore 2·(s+1).
- R3: A new setting written partway through a half-period does not shorten or stretch that half-period. The new length applies from the following half-period onward.
- R4: With the enable (address 1 bit 3) set and the selector (bits 1:0) equal to 0, `pinOut[3]` follows the oscillator clock itself.
- R5: With the enable set and the selector equal to 1, `pinOut[3]` carries the prescaled clock: s+1 cycles high and s+1 cycles low.
- R6: With the enable set and the selector equal to 2, `pinOut[3]` carries the prescaled clock divided by 64: 64·(s+1) cycles high and 64·(s+1) cycles low. This tap changes only in a cycle in which `prsClk` has just risen.
- R7: With the enable set and the selector equal to 3, `pinOut[3]` carries the prescaled clock divided by 512: 512·(s+1) cycles high and 512·(s+1) cycles low. This tap changes only in a cycle in which `prsClk` has just risen.
- R8: With the enable clear, `pinOut[3]` equals data bit 3, whatever the selector holds.
- R9: `pinOut[2:0]` always equals data bits 2:0. Each `pinOe[i]` is the inverse of high-impedance bit i, one cycle after that bit is written.
- R10: Bit 2 of address 1 always reads 0, even after a one is written to it.
- R11: Every writable bit reads back the value last written to it, one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address |
| busWdata | input | 4 | Write data |
| busRdata | output | 4 | Read data for `busAddr` (combinational) |
| prsClk | output | 1 | Prescaled reference clock |
| pinOut | output | 4 | Output pin values, pin 3 may carry the selected clock |
| pinOe | output | 4 | Output pin drive enables (1 = driving) |

## Verification
The following are checked on every cycle:
- Each half-period of the prescaled clock is compared against the setting that was loaded when that half began, which covers R2 and R3 together.
- Both slow taps are checked to move only on a rising edge of the prescaled clock.
- The control register's unused bit is checked to read as zero.
- Register and high-impedance writes are checked to land one cycle later.

The following need the bench's scenarios:
- The absolute half-period lengths across all sixteen settings, and those of the 1/64 and 1/512 taps.
- The raw oscillator appearing on the pin.
- The data-bit fallback when the enable is clear.
- The exact lengths when the setting changes in the middle of a half-period.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam int PRS_W  = 4;
  localparam int PORT_W = 4;
  localparam int SEL_W  = 2;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_PRS  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTL  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_HIZ  = 2'd3;

  localparam logic [PRS_W-1:0] PRS_RESET = '1;

  // Configuration handed from the register side to the datapath
  typedef struct packed {
    logic [PRS_W-1:0]  prsm;
    logic              clkOutEn;
    logic [SEL_W-1:0]  clkSel;
    logic [PORT_W-1:0] portData;
    logic [PORT_W-1:0] hiZ;
  } prs_cfg_t;
endpackage

// File: rtl/prs_regs.sv
module prs_regs
  import prs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PRS_W-1:0]  busWdata,
  output logic [PRS_W-1:0]  busRdata,
  output prs_cfg_t          cfg
);
  // Bit positions inside the clock-output control register
  localparam int EN_BIT = 3;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg.prsm     <= PRS_RESET;
      cfg.clkOutEn <= 1'b0;
      cfg.clkSel   <= '0;
      cfg.portData <= '1;
      cfg.hiZ      <= '0;
    end else if (busWr) begin
      unique case (busAddr)
        ADDR_PRS:  cfg.prsm <= busWdata;
        ADDR_CTL: begin
          cfg.clkOutEn <= busWdata[EN_BIT];
          cfg.clkSel   <= busWdata[SEL_W-1:0];
        end
        ADDR_DATA: cfg.portData <= busWdata;
        default:   cfg.hiZ <= busWdata;
      endcase
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      ADDR_PRS:  busRdata = cfg.prsm;
      ADDR_CTL: begin
        busRdata[EN_BIT]      = cfg.clkOutEn;
        busRdata[SEL_W-1:0]   = cfg.clkSel;
      end
      ADDR_DATA: busRdata = cfg.portData;
      default:   busRdata = cfg.hiZ;
    endcase
  end

  // R10
  unused_bit_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_CTL) |-> (busRdata[2] == 1'b0));

  // R11
  prs_write_land_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_PRS) |=> (cfg.prsm == $past(busWdata)));

  // R11
  data_write_land_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_DATA) |=> (cfg.portData == $past(busWdata)));
endmodule

// File: rtl/prs_datapath.sv
module prs_datapath
  import prs_pkg::*;
#(
  parameter int TAP_A_LOG2 = 6,
  parameter int TAP_B_LOG2 = 9,
  parameter int CLK_PIN    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  prs_cfg_t          cfg,
  output logic              prsClk,
  output logic [PORT_W-1:0] pinOut,
  output logic [PORT_W-1:0] pinOe
);
  localparam int RUN_W = PRS_W + 1;

  logic [PRS_W-1:0]      divCnt;
  logic                  prsQ;
  logic                  prsTerm;
  logic                  prsRise;
  logic [TAP_B_LOG2-1:0] riseCnt;
  logic                  tapA;
  logic                  tapB;
  logic                  clkMux;

  assign prsTerm = (divCnt == '0);
  assign prsRise = prsTerm && !prsQ;

  // Down-counter reloads from the live setting only at terminal count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= PRS_RESET;
      prsQ   <= 1'b0;
    end else if (prsTerm) begin
      divCnt <= cfg.prsm;
      prsQ   <= ~prsQ;
    end else begin
      divCnt <= divCnt - 1'b1;
    end
  end

  // Tap counter advances once per prescaled rising edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) riseCnt <= '0;
    else if (prsRise) riseCnt <= riseCnt + 1'b1;
  end

  assign tapA   = riseCnt[TAP_A_LOG2-1];
  assign tapB   = riseCnt[TAP_B_LOG2-1];
  assign prsClk = prsQ;

  always_comb begin
    unique case (cfg.clkSel)
      2'd0:    clkMux = clk;
      2'd1:    clkMux = prsQ;
      2'd2:    clkMux = tapA;
      default: clkMux = tapB;
    endcase
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    if (i == CLK_PIN) begin : g_clk
      assign pinOut[i] = cfg.clkOutEn ? clkMux : cfg.portData[i];
    end else begin : g_plain
      assign pinOut[i] = cfg.portData[i];
    end
    assign pinOe[i] = ~cfg.hiZ[i];
  end

  // Half-period monitor: measures each level of prsClk as seen from outside
  logic             prsPrev;
  logic [RUN_W-1:0] runLen;
  logic [PRS_W-1:0] prsmQ;
  logic [PRS_W-1:0] lenExp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prsPrev <= 1'b0;
      runLen  <= '0;
      prsmQ   <= PRS_RESET;
      lenExp  <= PRS_RESET;
    end else begin
      prsPrev <= prsClk;
      prsmQ   <= cfg.prsm;
      if (prsClk != prsPrev) begin
        runLen <= RUN_W'(1);
        lenExp <= prsmQ;
      end else begin
        runLen <= runLen + 1'b1;
      end
    end
  end

  // R3
  half_period_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prsClk != prsPrev) |-> (runLen == RUN_W'(lenExp) + RUN_W'(1)));

  // R6
  tap_a_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tapA != $past(tapA)) |-> $rose(prsClk));

  // R7
  tap_b_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tapB != $past(tapB)) |-> $rose(prsClk));
endmodule

// File: rtl/prs_clkout.sv
module prs_clkout
  import prs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [1:0]  busAddr,
  input  logic [3:0]  busWdata,
  output logic [3:0]  busRdata,
  output logic        prsClk,
  output logic [3:0]  pinOut,
  output logic [3:0]  pinOe
);
  prs_cfg_t cfg;

  prs_regs u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .cfg      (cfg)
  );

  prs_datapath #(
    .TAP_A_LOG2 (6),
    .TAP_B_LOG2 (9),
    .CLK_PIN    (3)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cfg    (cfg),
    .prsClk (prsClk),
    .pinOut (pinOut),
    .pinOe  (pinOe)
  );

  // R9
  hiz_to_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_HIZ) |=> (pinOe == ~$past(busWdata)));
endmodule

// File: tb/tb_prs_clkout.sv
module tb_prs_clkout;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0;
  logic [1:0] busAddr = '0;
  logic [3:0] busWdata = '0;
  logic [3:0] busRdata;
  logic       prsClk;
  logic [3:0] pinOut;
  logic [3:0] pinOe;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prs_clkout dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .prsClk(prsClk),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [3:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  function automatic bit sig(input bit usePin);
    return usePin ? pinOut[3] : prsClk;
  endfunction

  task automatic measure(input bit usePin, output int hi, output int lo);
    @(negedge clk);
    while (sig(usePin) == 1'b1) @(negedge clk);
    while (sig(usePin) == 1'b0) @(negedge clk);
    hi = 0;
    while (sig(usePin) == 1'b1) begin hi++; @(negedge clk); end
    lo = 0;
    while (sig(usePin) == 1'b0) begin lo++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [3:0] rv;
    int hi, lo;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset values
    rd(2'd0, rv); check(rv == 4'd15, "R1 setting", rv, 15);
    rd(2'd1, rv); check(rv == 4'd0,  "R1 control", rv, 0);
    rd(2'd2, rv); check(rv == 4'hF,  "R1 data", rv, 15);
    rd(2'd3, rv); check(rv == 4'd0,  "R1 hiz", rv, 0);
    check(pinOut == 4'hF, "R1 pinOut", pinOut, 15);
    check(pinOe == 4'hF, "R1 pinOe", pinOe, 15);
    check(prsClk == 1'b0, "R1 prsClk", prsClk, 0);

    // R11 and R10: readback sweeps
    for (int v = 0; v < 16; v++) begin
      wr(2'd0, 4'(v)); rd(2'd0, rv); check(rv == 4'(v), "R11 setting", rv, v);
      wr(2'd2, 4'(v)); rd(2'd2, rv); check(rv == 4'(v), "R11 data", rv, v);
      wr(2'd3, 4'(v)); rd(2'd3, rv); check(rv == 4'(v), "R11 hiz", rv, v);
      check(pinOe == ~4'(v), "R9 pinOe", pinOe, int'(~4'(v)));
      wr(2'd1, 4'(v)); rd(2'd1, rv);
      check(rv == (4'(v) & 4'b1011), "R10 control bit2", rv, v & 11);
    end

    // R9 and R8: plain pins, data fallback with enable clear
    wr(2'd3, 4'b0110);
    wr(2'd2, 4'b0101);
    wr(2'd1, 4'b0011);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(pinOut == 4'b0101, "R8 data bit on clock pin", pinOut, 5);
    end
    check(pinOe == 4'b1001, "R9 oe mix", pinOe, 9);
    wr(2'd3, 4'b0000);
    wr(2'd2, 4'b1010);
    wr(2'd1, 4'b1001);
    @(negedge clk);
    check(pinOut[2:0] == 3'b010, "R9 plain pins under clock out", pinOut[2:0], 2);

    // R2: sweep every setting on prsClk
    wr(2'd1, 4'b0000);
    wr(2'd2, 4'hF);
    for (int s = 0; s < 16; s++) begin
      wr(2'd0, 4'(s));
      measure(1'b0, hi, lo);
      check(hi == s + 1, "R2 high", hi, s + 1);
      check(lo == s + 1, "R2 low", lo, s + 1);
    end

    // R5: prescaled clock on pin
    for (int s = 0; s < 16; s += 5) begin
      wr(2'd0, 4'(s));
      wr(2'd1, 4'b1001);
      measure(1'b1, hi, lo);
      check(hi == s + 1 && lo == s + 1, "R5 pin prescaled", hi + lo, 2 * (s + 1));
    end

    // R6: /64 tap
    for (int s = 0; s < 3; s++) begin
      wr(2'd0, 4'(s));
      wr(2'd1, 4'b1010);
      measure(1'b1, hi, lo);
      check(hi == 64 * (s + 1), "R6 tap64 high", hi, 64 * (s + 1));
      check(lo == 64 * (s + 1), "R6 tap64 low", lo, 64 * (s + 1));
    end

    // R7: /512 tap
    for (int s = 0; s < 2; s++) begin
      wr(2'd0, 4'(s));
      wr(2'd1, 4'b1011);
      measure(1'b1, hi, lo);
      check(hi == 512 * (s + 1), "R7 tap512 high", hi, 512 * (s + 1));
      check(lo == 512 * (s + 1), "R7 tap512 low", lo, 512 * (s + 1));
    end

    // R4: raw oscillator on pin
    wr(2'd1, 4'b1000);
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #(CLK_PERIOD/4);
      check(pinOut[3] == 1'b1, "R4 osc high phase", pinOut[3], 1);
      @(negedge clk); #(CLK_PERIOD/4);
      check(pinOut[3] == 1'b0, "R4 osc low phase", pinOut[3], 0);
    end

    // R3: setting changed partway through a high phase
    wr(2'd1, 4'b0000);
    wr(2'd0, 4'd3);
    @(negedge clk);
    while (prsClk) @(negedge clk);
    while (!prsClk) @(negedge clk);
    hi = 1;
    busWr = 1'b1; busAddr = 2'd0; busWdata = 4'd7;
    @(negedge clk);
    busWr = 1'b0;
    while (prsClk) begin hi++; @(negedge clk); end
    lo = 0;
    while (!prsClk) begin lo++; @(negedge clk); end
    check(hi == 4, "R3 running half keeps old length", hi, 4);
    check(lo == 8, "R3 next half uses new length", lo, 8);
    hi = 0;
    while (prsClk) begin hi++; @(negedge clk); end
    check(hi == 8, "R3 later half uses new length", hi, 8);

    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule